// File: doc/BRIEF.md
# Peak-Current PWM Switching Latch

This block holds the cycle-by-cycle switching logic of a peak-current-mode buck controller in digital form. A cycle-start pulse sets an on-request. The high-side gate command follows the request once the low side has been off for a dead-time interval. The request is cleared by a current-comparator trip or by a maximum-duty pulse that arrives a fixed interval before the next cycle start. After the request clears, the high side turns off and the low side turns on after another dead-time gap. The outputs then stay in that state until the next cycle start.

All timing is counted in cycles of a fast system clock. The comparator input is blanked for a programmable number of cycles after each high-side turn-on, so that the switching edge cannot end the pulse early. The sensing, the error amplifier and the gate drivers are outside the block. The block sees only the digital trip, the two timing pulses and an enable. When the enable is low, both gate commands are held off.

Top module: `pcm_switch_latch`

## Requirements
- R1: While reset is low both gate commands are 0. After reset is released with the enable high, the low-side command rises after DEAD_CYC cycles with both commands off.
- R2: A cycle-start pulse sets the on-request. The high-side command rises once the low side has been off for DEAD_CYC consecutive cycles.
- R3: A comparator trip sampled after the blanking window clears the request on that edge, and the high-side command falls on the following edge.
- R4: A trip is ignored during the first BLANK_CYC cycles after the high-side command rises, and while the high side is off.
- R5: A maximum-duty pulse clears the request whether or not a trip has occurred, so the high-side command falls on the next edge.
- R6: A trip and a maximum-duty pulse in the same cycle produce exactly one high-side falling edge.
- R7: After either command falls, both commands stay off for exactly DEAD_CYC cycles before the other command rises.
- R8: The high-side and low-side commands are never 1 together.
- R9: Once the request is cleared, further trips and maximum-duty pulses have no effect until the next cycle start.
- R10: With the enable low, both commands are 0 after the next edge and the request is cleared.
- R11: A cycle start in the same cycle as a trip or a maximum-duty pulse takes priority, and the request is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable; low holds both gates off |
| cycle_start | input | 1 | One-cycle pulse that starts a switching period |
| max_duty | input | 1 | One-cycle pulse that forces turn-off ahead of the next period |
| cmp_trip | input | 1 | Digital peak-current comparator output |
| hs_on | output | 1 | High-side gate command |
| ls_on | output | 1 | Low-side gate command |

## Verification
The assertions check several properties on every cycle. They check that the two gate commands never overlap and that a rising command always follows a cycle with the other command off. They also check that the enable forces both commands off, that no trip passes in the cycle the high side turns on, and that a cleared request stays cleared without a cycle start. The bench scenarios are needed to show the exact counts: the dead-time gap length, where the blanking window ends, the single falling edge when a trip and a maximum-duty pulse coincide, and the priority of the cycle start. A cycle-level reference model in the bench compares both outputs against random pulse trains and directed corner cases.

// File: rtl/pcm_pkg.sv
// Shared types for the switching latch.
// Assumes: single clock domain, all inputs already synchronous.
package pcm_pkg;
    typedef struct packed {
        logic hs;
        logic ls;
    } gate_cmd_t;

    localparam gate_cmd_t GATES_OFF = '{hs: 1'b0, ls: 1'b0};
endpackage

// File: rtl/pcm_blank_filter.sv
// Leading-edge blanking: passes the comparator trip only once the high
// side has been on for BLANK_CYC cycles.
// Assumes: BLANK_CYC >= 1; hs_on is the registered high-side command.
module pcm_blank_filter #(
    parameter int BLANK_CYC = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_on,
    input  logic cmp_trip,
    output logic trip_valid
);
    localparam int CW = $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] BLANK_END = CW'(BLANK_CYC);

    logic [CW-1:0] on_cnt;

    // Count cycles since high-side turn-on, saturating at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n || !hs_on)
            on_cnt <= '0;
        else if (on_cnt != BLANK_END)
            on_cnt <= on_cnt + 1'b1;
    end

    // Trip is honoured only with the high side on and the window expired.
    always_comb trip_valid = cmp_trip && hs_on && (on_cnt == BLANK_END);

    // R4
    blank_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> !trip_valid);
endmodule

// File: rtl/pcm_turnoff_latch.sv
// Set-reset request latch: cycle start sets, blanked trip or max-duty
// pulse clears. Set wins a tie; disable clears.
// Assumes: pulses are one cycle wide and synchronous.
module pcm_turnoff_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cycle_start,
    input  logic max_duty,
    input  logic trip_valid,
    output logic req
);
    // Update the on-request with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            req <= 1'b0;
        else if (cycle_start)
            req <= 1'b1;
        else if (max_duty || trip_valid)
            req <= 1'b0;
    end

    // R9
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !cycle_start) |=> !req);
    // R5
    max_duty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (max_duty && !cycle_start) |=> !req);
    // R11
    start_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && enable) |=> req);
endmodule

// File: rtl/pcm_dead_time.sv
// Break-before-make gate sequencer: drops the active gate when the
// request disagrees, waits DEAD_CYC cycles with both off, then raises
// the gate the request selects.
// Assumes: DEAD_CYC >= 1.
module pcm_dead_time
    import pcm_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      req,
    output gate_cmd_t gates
);
    localparam int DW = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] GAP_LAST = DW'(DEAD_CYC - 1);

    logic [DW-1:0] gap_cnt;

    // Sequence the two gate commands with a counted gap between them.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            gates   <= GATES_OFF;
            gap_cnt <= '0;
        end else if (gates.hs && !req) begin
            gates.hs <= 1'b0;
            gap_cnt  <= '0;
        end else if (gates.ls && req) begin
            gates.ls <= 1'b0;
            gap_cnt  <= '0;
        end else if (!gates.hs && !gates.ls) begin
            if (gap_cnt == GAP_LAST) begin
                gates.hs <= req;
                gates.ls <= !req;
                gap_cnt  <= '0;
            end else begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates.hs && gates.ls));
    // R7
    hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gates.hs) |-> $past(!gates.ls));
    // R7
    ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gates.ls) |-> $past(!gates.hs));
    // R10
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!gates.hs && !gates.ls));
endmodule

// File: rtl/pcm_switch_latch.sv
// Peak-current switching latch top: blanking filter, request latch and
// dead-time sequencer in a loop through the high-side command.
// Assumes: synchronous inputs; timing parameters in system clock cycles.
module pcm_switch_latch
    import pcm_pkg::*;
#(
    parameter int BLANK_CYC = 11,
    parameter int DEAD_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cycle_start,
    input  logic max_duty,
    input  logic cmp_trip,
    output logic hs_on,
    output logic ls_on
);
    logic      trip_valid;
    logic      req;
    gate_cmd_t gates;

    pcm_blank_filter #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk(clk), .rst_n(rst_n), .hs_on(gates.hs),
        .cmp_trip(cmp_trip), .trip_valid(trip_valid)
    );

    pcm_turnoff_latch u_latch (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cycle_start(cycle_start), .max_duty(max_duty),
        .trip_valid(trip_valid), .req(req)
    );

    pcm_dead_time #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .req(req), .gates(gates)
    );

    // Drive the gate command ports from the sequencer.
    always_comb begin
        hs_on = gates.hs;
        ls_on = gates.ls;
    end

    // R1
    reset_off_chk: assert property (@(posedge clk)
        !rst_n |=> (!hs_on && !ls_on));
endmodule

// File: tb/tb_pcm_switch_latch.sv
module tb_pcm_switch_latch;
    localparam int BLANK = 11;
    localparam int DEAD  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, cycle_start = 1'b0, max_duty = 1'b0, cmp_trip = 1'b0;
    logic hs_on, ls_on;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcm_switch_latch #(.BLANK_CYC(BLANK), .DEAD_CYC(DEAD)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cycle_start(cycle_start),
        .max_duty(max_duty), .cmp_trip(cmp_trip), .hs_on(hs_on), .ls_on(ls_on)
    );

    // Reference model built from the requirements.
    logic m_req = 0, m_hs = 0, m_ls = 0;
    int m_gap = 0, m_blk = 0, hs_falls = 0;
    always @(posedge clk) begin
        logic tv;
        tv = m_hs && (m_blk == BLANK) && cmp_trip;
        if (!rst_n) begin
            m_req <= 0; m_hs <= 0; m_ls <= 0; m_gap <= 0; m_blk <= 0;
        end else begin
            if (!enable) m_req <= 0;
            else if (cycle_start) m_req <= 1;
            else if (max_duty || tv) m_req <= 0;
            if (!enable) begin m_hs <= 0; m_ls <= 0; m_gap <= 0; end
            else if (m_hs && !m_req) begin m_hs <= 0; m_gap <= 0; end
            else if (m_ls && m_req) begin m_ls <= 0; m_gap <= 0; end
            else if (!m_hs && !m_ls) begin
                if (m_gap == DEAD - 1) begin m_hs <= m_req; m_ls <= !m_req; m_gap <= 0; end
                else m_gap <= m_gap + 1;
            end
            m_blk <= !m_hs ? 0 : (m_blk < BLANK ? m_blk + 1 : m_blk);
        end
        if (hs_on && !m_hs && rst_n && enable && m_req == 0) ; // no-op
    end

    function automatic bit mismatch(logic a, logic e);
        return a !== e;
    endfunction

    // One clock, then compare at the falling edge.
    task automatic step(string tag);
        @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (mismatch(hs_on, m_hs) || mismatch(ls_on, m_ls)) begin
            n_fail++;
            $display("FAIL %s: hs/ls actual %b%b expected %b%b", tag, hs_on, ls_on, m_hs, m_ls);
        end
        n_checks++;
        if (hs_on && ls_on) begin
            n_fail++;
            $display("FAIL R8: hs/ls actual 11 expected not both 1");
        end
        cycle_start = 0; max_duty = 0; cmp_trip = 0;
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic expect_pins(logic h, logic l, string tag);
        n_checks++;
        if (hs_on !== h || ls_on !== l) begin
            n_fail++;
            $display("FAIL %s: hs/ls actual %b%b expected %b%b", tag, hs_on, ls_on, h, l);
        end
    endtask

    initial begin
        int falls0;
        void'($urandom(32'h5EED_1234));
        run(3, "R1");
        expect_pins(0, 0, "R1 reset");
        rst_n = 1; enable = 1;
        run(DEAD, "R1");
        expect_pins(0, 1, "R1 low side after gap");
        // R2/R7: start a cycle, check gap then high side on
        cycle_start = 1; step("R2");
        expect_pins(0, 1, "R2 request registered");
        run(1, "R7"); expect_pins(0, 0, "R7 low side off");
        run(DEAD - 1, "R7"); expect_pins(0, 0, "R7 gap held");
        run(1, "R2"); expect_pins(1, 0, "R2 high side on");
        // R4: trip inside blanking window ignored
        for (int i = 0; i < BLANK; i++) begin cmp_trip = 1; step("R4"); end
        expect_pins(1, 0, "R4 blanked trips");
        // R3: trip after window
        cmp_trip = 1; step("R3"); expect_pins(1, 0, "R3 request cleared");
        run(1, "R3"); expect_pins(0, 0, "R3 high side off");
        run(DEAD, "R7"); expect_pins(0, 1, "R7 low side after gap");
        // R9: further pulses have no effect
        cmp_trip = 1; max_duty = 1; step("R9"); run(5, "R9");
        expect_pins(0, 1, "R9 held off");
        // R5: max duty with no trip
        cycle_start = 1; run(DEAD + 4, "R5");
        max_duty = 1; step("R5"); run(1, "R5");
        expect_pins(0, 0, "R5 forced off");
        run(DEAD, "R5");
        // R6: trip and max duty together after window
        cycle_start = 1; run(DEAD + BLANK + 3, "R6");
        expect_pins(1, 0, "R6 on before coincidence");
        cmp_trip = 1; max_duty = 1; step("R6");
        cmp_trip = 1; max_duty = 1; step("R6");
        expect_pins(0, 0, "R6 single turn-off");
        cmp_trip = 1; run(DEAD + 2, "R6");
        expect_pins(0, 1, "R6 no second pulse");
        // R11: cycle start with max duty and trip
        cycle_start = 1; max_duty = 1; cmp_trip = 1; step("R11");
        run(DEAD + 1, "R11"); expect_pins(1, 0, "R11 start wins");
        // R10: disable mid pulse
        enable = 0; step("R10"); expect_pins(0, 0, "R10 both off");
        cycle_start = 1; enable = 0; step("R10"); run(2, "R10");
        expect_pins(0, 0, "R10 start ignored while off");
        enable = 1; run(DEAD + 1, "R10");
        expect_pins(0, 1, "R10 request cleared on re-enable");
        // Random pulse trains against the model.
        for (int p = 0; p < 400; p++) begin
            int per;
            per = 20 + int'($urandom_range(0, 30));
            for (int c = 0; c < per; c++) begin
                cycle_start = (c == 0);
                max_duty = (c == per - 2);
                cmp_trip = ($urandom_range(0, 9) == 0);
                if ($urandom_range(0, 499) == 0) enable = 0; else enable = 1;
                step("R8 random");
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule